// File: doc/BRIEF.md
# Serial Target Word Receiver

This block takes a 16-bit status word that an external controller shifts in over a two-wire serial link: a clock line and a data line. Both lines are asynchronous to the system clock. They pass through a synchronizer and are sampled on each rising edge of the serial clock. The bits are assembled least-significant bit first. A completed word is accepted only if its first bit carries the start marker. An accepted word then updates a set of latched indicator registers: three trip flags, six current-sense flags, a pole-mode bit and a two-bit release code.

A load flag inside the word decides which fields take effect. When the flag is clear, every field is applied. When the flag is set, the target and mode fields are left alone and only the release code is updated. The unused release code value never reaches the outputs. If the serial clock goes idle partway through a word, an idle timeout drops the partial bits, so the next word starts aligned. Each accepted word produces a one-cycle strobe.

Top module: `serial_target_rx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every target flag is 0, `pole_three` is 0 (single-pole), `rel_code` is 0 and `word_stb` is 0.
- R2: Bits are taken LSB first, so the first bit shifted in is word bit 0. Word bits 3..1 map to `trip_flags[2:0]`, bit 4 to `pole_three`, bits 13..8 to `cs_flags[5:0]`, and bits 15..14 to `rel_code[1:0]`. Bit 7 is the load flag and bits 6..5 carry no meaning.
- R3: Results and `word_stb` appear after the fourth rising edge of `clk` that follows the rise of `ser_clk` for word bit 15.
- R4: A word whose bit 0 is 0 is discarded. No strobe is issued and no output changes.
- R5: An accepted word with load flag 1 leaves the trip flags, current-sense flags and `pole_three` unchanged, but still updates `rel_code`.
- R6: An accepted word with load flag 0 updates every target flag, `pole_three` and `rel_code`.
- R7: A release code of 2'b11 is not applied, and the previously latched code is kept. The outputs never show 2'b11.
- R8: If `ser_clk` shows no rising edge for `IDLE_TIMEOUT` clock cycles during a partial word, the partial bits are dropped and the next edge starts a new word at bit 0.
- R9: `word_stb` is high for exactly one cycle per accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the sender, asynchronous |
| ser_dat | input | 1 | Serial data, sampled on ser_clk rising edges |
| trip_flags | output | 3 | Latched phase trip targets, 1 = on |
| cs_flags | output | 6 | Latched current-sense targets, 1 = on |
| pole_three | output | 1 | 1 = three-pole, 0 = single-pole |
| rel_code | output | 2 | Latched trip release code |
| word_stb | output | 1 | One-cycle pulse when an accepted word is applied |

## Verification
Every result is due on the fourth `clk` rising edge after the final `ser_clk` rise. That delay is made up of two synchronizer stages, the edge register and the output register. Each directed task raises `ser_clk` on a falling edge of `clk` and counts exactly four rising edges. It then samples on the next falling edge, where the strobe and the new field values must be present, and samples once more a cycle later, where the strobe must have fallen. Discarded words are checked over a twelve-cycle window that covers the whole latency. Timeout behaviour is checked by following a stalled partial word with a full word, which must be decoded with correct alignment.

// File: rtl/tgt_rx_pkg.sv
package tgt_rx_pkg;
  localparam int WORD_W    = 16;
  localparam int POS_START = 0;
  localparam int POS_TRIP  = 1;
  localparam int N_TRIP    = 3;
  localparam int POS_MODE  = 4;
  localparam int POS_LOAD  = 7;
  localparam int POS_CS    = 8;
  localparam int N_CS      = 6;
  localparam int POS_REL   = 14;
  localparam int REL_W     = 2;

  typedef enum logic [REL_W-1:0] {
    REL_SENSE_AND_TRIP = 2'b00,
    REL_TRIP_DELAYED   = 2'b01,
    REL_TRIP_AT_ONCE   = 2'b10,
    REL_RESERVED       = 2'b11
  } rel_code_e;
endpackage

// File: rtl/tgt_sync.sv
module tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic ser_dat,
  output logic clk_rise,
  output logic dat_s
);
  logic [STAGES-1:0] clk_pipe;
  logic [STAGES-1:0] dat_pipe;
  logic              clk_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_pipe[0] <= 1'b0;
      dat_pipe[0] <= 1'b0;
    end else begin
      clk_pipe[0] <= ser_clk;
      dat_pipe[0] <= ser_dat;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        clk_pipe[g] <= 1'b0;
        dat_pipe[g] <= 1'b0;
      end else begin
        clk_pipe[g] <= clk_pipe[g-1];
        dat_pipe[g] <= dat_pipe[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) clk_last <= 1'b0;
    else     clk_last <= clk_pipe[STAGES-1];
  end

  assign clk_rise = clk_pipe[STAGES-1] & ~clk_last;
  assign dat_s    = dat_pipe[STAGES-1];
endmodule

// File: rtl/tgt_shift.sv
module tgt_shift
  import tgt_rx_pkg::*;
#(
  parameter int IDLE_TIMEOUT = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              bit_val,
  output logic              word_done,
  output logic [WORD_W-1:0] word_q
);
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int IDLE_W = $clog2(IDLE_TIMEOUT + 1);
  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(WORD_W - 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_TIMEOUT - 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic [IDLE_W-1:0] idle_cnt;
  logic [WORD_W-1:0] next_shreg;

  assign next_shreg = {bit_val, shreg[WORD_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      bit_cnt   <= '0;
      idle_cnt  <= '0;
      word_done <= 1'b0;
      word_q    <= '0;
    end else begin
      word_done <= 1'b0;
      if (bit_en) begin
        shreg    <= next_shreg;
        idle_cnt <= '0;
        if (bit_cnt == LAST_BIT) begin
          bit_cnt   <= '0;
          word_q    <= next_shreg;
          word_done <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (bit_cnt != '0) begin
        if (idle_cnt == IDLE_LAST) begin
          bit_cnt  <= '0;
          idle_cnt <= '0;
        end else begin
          idle_cnt <= idle_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tgt_latch.sv
module tgt_latch
  import tgt_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word,
  output logic [N_TRIP-1:0] trip_flags,
  output logic [N_CS-1:0]   cs_flags,
  output logic              pole_three,
  output logic [REL_W-1:0]  rel_code,
  output logic              word_stb
);
  logic       accept;
  logic       take_targets;
  rel_code_e  new_rel;
  logic [1:0] unused_bits;

  assign unused_bits  = word[6:5];
  assign new_rel      = rel_code_e'(word[POS_REL +: REL_W]);
  assign accept       = word_done & word[POS_START];
  assign take_targets = accept & ~word[POS_LOAD];

  always_ff @(posedge clk) begin
    if (rst) begin
      trip_flags <= '0;
      cs_flags   <= '0;
      pole_three <= 1'b0;
      rel_code   <= REL_SENSE_AND_TRIP;
      word_stb   <= 1'b0;
    end else begin
      word_stb <= accept;
      if (take_targets) begin
        trip_flags <= word[POS_TRIP +: N_TRIP];
        cs_flags   <= word[POS_CS +: N_CS];
        pole_three <= word[POS_MODE];
      end
      if (accept && new_rel != REL_RESERVED) begin
        rel_code <= new_rel;
      end
    end
  end
endmodule

// File: rtl/serial_target_rx.sv
module serial_target_rx
  import tgt_rx_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int IDLE_TIMEOUT = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic [N_TRIP-1:0] trip_flags,
  output logic [N_CS-1:0]   cs_flags,
  output logic              pole_three,
  output logic [REL_W-1:0]  rel_code,
  output logic              word_stb
);
  logic              clk_rise;
  logic              dat_s;
  logic              word_done;
  logic [WORD_W-1:0] word_q;

  tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .ser_clk  (ser_clk),
    .ser_dat  (ser_dat),
    .clk_rise (clk_rise),
    .dat_s    (dat_s)
  );

  tgt_shift #(.IDLE_TIMEOUT(IDLE_TIMEOUT)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (clk_rise),
    .bit_val   (dat_s),
    .word_done (word_done),
    .word_q    (word_q)
  );

  tgt_latch u_latch (
    .clk        (clk),
    .rst        (rst),
    .word_done  (word_done),
    .word       (word_q),
    .trip_flags (trip_flags),
    .cs_flags   (cs_flags),
    .pole_three (pole_three),
    .rel_code   (rel_code),
    .word_stb   (word_stb)
  );
endmodule

// File: rtl/tgt_rx_checker.sv
module tgt_rx_checker
  import tgt_rx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              word_done,
  input logic [WORD_W-1:0] word_q,
  input logic [N_TRIP-1:0] trip_flags,
  input logic [N_CS-1:0]   cs_flags,
  input logic              pole_three,
  input logic [REL_W-1:0]  rel_code,
  input logic              word_stb
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (trip_flags == '0 && cs_flags == '0 && !pole_three && rel_code == '0 && !word_stb)); // R1
  AST_NO_START_NO_STB: assert property (@(posedge clk) disable iff (rst) (word_done && !word_q[POS_START]) |=> !word_stb); // R4
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst) !word_stb |-> ($stable(trip_flags) && $stable(cs_flags) && $stable(pole_three) && $stable(rel_code))); // R4
  AST_LOAD_SET_KEEPS: assert property (@(posedge clk) disable iff (rst) (word_done && word_q[POS_START] && word_q[POS_LOAD]) |=> ($stable(trip_flags) && $stable(cs_flags) && $stable(pole_three))); // R5
  AST_LOAD_CLR_TAKES: assert property (@(posedge clk) disable iff (rst) (word_done && word_q[POS_START] && !word_q[POS_LOAD]) |=> (trip_flags == $past(word_q[POS_TRIP +: N_TRIP]) && cs_flags == $past(word_q[POS_CS +: N_CS]))); // R6
  AST_NO_RESERVED_CODE: assert property (@(posedge clk) disable iff (rst) rel_code != 2'b11); // R7
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst) word_stb |=> !word_stb); // R9
endmodule

bind serial_target_rx tgt_rx_checker u_tgt_rx_checker (
  .clk        (clk),
  .rst        (rst),
  .word_done  (word_done),
  .word_q     (word_q),
  .trip_flags (trip_flags),
  .cs_flags   (cs_flags),
  .pole_three (pole_three),
  .rel_code   (rel_code),
  .word_stb   (word_stb)
);

// File: tb/test_serial_target_rx.sv
module test_serial_target_rx;
  localparam int CLK_PERIOD = 10;
  localparam int PH         = 4;
  localparam int TIMEOUT    = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_dat = 1'b0;
  logic [2:0] trip_flags;
  logic [5:0] cs_flags;
  logic       pole_three;
  logic [1:0] rel_code;
  logic       word_stb;

  int n_chk  = 0;
  int n_fail = 0;
  logic       done = 1'b0;
  logic [2:0] e_trip = '0;
  logic [5:0] e_cs   = '0;
  logic       e_mode = 1'b0;
  logic [1:0] e_rel  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_target_rx #(.SYNC_STAGES(2), .IDLE_TIMEOUT(TIMEOUT)) i_serial_target_rx (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .trip_flags(trip_flags), .cs_flags(cs_flags), .pole_three(pole_three),
    .rel_code(rel_code), .word_stb(word_stb)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(logic st, logic [2:0] tr, logic md, logic ld,
                                     logic [5:0] cs, logic [1:0] rl);
    return {rl, cs, ld, 2'b00, md, tr, st};
  endfunction

  task automatic shift_bits(logic [15:0] w, int nbits);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = w[i];
      repeat (PH) @(negedge clk);
      ser_clk = 1'b1;
      if (i != 15) begin
        repeat (PH) @(negedge clk);
        ser_clk = 1'b0;
      end
    end
  endtask

  // Model from the requirements: R5/R6 field selection, R7 code filter.
  task automatic model(logic [15:0] w);
    if (w[0]) begin
      if (!w[7]) begin
        e_trip = w[3:1];
        e_cs   = w[13:8];
        e_mode = w[4];
      end
      if (w[15:14] != 2'b11) e_rel = w[15:14];
    end
  endtask

  task automatic check_fields(string req);
    chk({req, " trip"}, 16'(trip_flags), 16'(e_trip));
    chk({req, " cs"},   16'(cs_flags),   16'(e_cs));
    chk({req, " mode"}, 16'(pole_three), 16'(e_mode));
    chk({req, " rel"},  16'(rel_code),   16'(e_rel));
  endtask

  // R3 latency: outputs due after the fourth clk rise after the last ser_clk rise.
  task automatic send_accepted(logic [15:0] w, string req);
    shift_bits(w, 16);
    model(w);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({req, " R3 stb early"}, 16'(word_stb), 16'd0);
    @(posedge clk);
    @(negedge clk);
    chk({req, " R3 stb"}, 16'(word_stb), 16'd1);
    check_fields(req);
    @(negedge clk);
    chk({req, " R9 stb one cycle"}, 16'(word_stb), 16'd0);
    ser_clk = 1'b0;
    repeat (PH) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 stb", 16'(word_stb), 16'd0);
    check_fields("R1");
    rst = 1'b0;
    @(negedge clk);
    check_fields("R1 after release");
  endtask

  task automatic t_full_load();
    send_accepted(mk(1'b1, 3'b101, 1'b1, 1'b0, 6'b100110, 2'b01), "R2 R6 pattern A");
    send_accepted(mk(1'b1, 3'b010, 1'b0, 1'b0, 6'b011001, 2'b10), "R2 R6 pattern B");
  endtask

  task automatic t_load_flag_set();
    send_accepted(mk(1'b1, 3'b111, 1'b1, 1'b1, 6'b111111, 2'b00), "R5 load set");
    chk("R5 trip kept", 16'(trip_flags), 16'b010);
    chk("R5 rel taken", 16'(rel_code), 16'b00);
  endtask

  task automatic t_reserved_code();
    send_accepted(mk(1'b1, 3'b110, 1'b1, 1'b0, 6'b000011, 2'b10), "R7 setup");
    send_accepted(mk(1'b1, 3'b001, 1'b0, 1'b0, 6'b101010, 2'b11), "R7 reserved");
    chk("R7 rel kept", 16'(rel_code), 16'b10);
  endtask

  task automatic t_no_start();
    int pulses = 0;
    shift_bits(mk(1'b0, 3'b111, 1'b1, 1'b0, 6'b111111, 2'b01), 16);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (word_stb) pulses++;
    end
    chk("R4 no stb", 16'(pulses), 16'd0);
    check_fields("R4 unchanged");
    ser_clk = 1'b0;
    repeat (PH) @(negedge clk);
  endtask

  task automatic t_timeout();
    shift_bits(16'hFFFF, 5);
    repeat (TIMEOUT + 20) @(negedge clk);
    send_accepted(mk(1'b1, 3'b011, 1'b0, 1'b0, 6'b110001, 2'b01), "R8 realign");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    repeat (4) @(negedge clk);
    t_full_load();
    t_load_flag_set();
    t_reserved_code();
    t_no_start();
    t_timeout();
    send_accepted(mk(1'b1, 3'b111, 1'b0, 1'b0, 6'b111111, 2'b00), "R2 R6 all ones");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule